// File: doc/BRIEF.md
# Dual-Edge Input Capture Unit

This block time-stamps transitions on a single external input. A free-running timer value comes in on `count_i`. When a chosen transition arrives, one of two capture circuits copies that value into its own register. Each circuit has its own edge field, so one circuit can stamp rising transitions while the other stamps falling ones. Software can then take the period or the pulse width from the difference between the two stamps. A typical use is measuring tachometer pulses from a fan.

Captures only happen while the unit is armed. In free-running mode, both circuits keep capturing for as long as the arm bit stays set. In one-shot mode, circuit 0 captures once, then circuit 1 captures once on a later edge, and after that the unit disarms itself.

An optional edge counter counts every transition of the synchronized input. It compares its count against a programmable value, and on each match it inverts a divided output. A source-select bit lets both capture circuits watch this divided output instead of the raw input, which is useful for timing over several input periods at once.

Top module: `cap_unit`

## Requirements
- R1: Each edge field is 2 bits: 00 captures nothing, 01 captures falling edges, 10 captures rising edges and 11 captures both edges of the capture source.
- R2: Circuit 0 (`edge0_i`, `cap0_o`, `flag_o[0]`) and circuit 1 (`edge1_i`, `cap1_o`, `flag_o[1]`) work independently. A capture by one leaves the other circuit's register unchanged.
- R3: While `arm_o` is 0, neither capture register changes and no flag is set. A pulse on `arm_clr_i` drops `arm_o` on the next clock. `arm_clr_i` takes priority over `arm_set_i`.
- R4: In free-running mode (`oneshot_i` = 0), while armed, every selected edge causes a capture.
- R5: In one-shot mode (`oneshot_i` = 1), arming with `arm_set_i` starts a sequence with three steps:
  - circuit 0 captures on its first selected edge;
  - circuit 1 captures on its first selected edge in a later cycle;
  - `arm_o` then clears, and no further captures occur.
- R6: A capture sets that circuit's bit in `flag_o`, and the bit stays set. Writing 1 to the matching bit of `flag_clr_i` clears it. If a capture and a clear happen in the same cycle, the flag stays set.
- R7: The input passes through a two-flop synchronizer. Suppose `sig_i` takes a new level that is first sampled at clock edge n. In raw mode (`src_sel_i` = 0), the capture register then loads the `count_i` value sampled at edge n+2.
- R8: With `ecnt_en_i` = 1, `ecnt_o` advances on each rising and falling edge of the synchronized input. With `ecnt_en_i` = 0, `ecnt_o` and `cmp_o` are held at 0.
- R9: When an edge would advance the count to `ecnt_cmp_i`, `ecnt_o` returns to 0 and `cmp_o` inverts instead.
- R10: With `src_sel_i` = 1, the capture circuits use `cmp_o` edges as their source. For an input level first sampled at edge n that inverts `cmp_o`, the capture takes the `count_i` value sampled at edge n+3.
- R11: After reset, both capture registers, `flag_o`, `arm_o`, `ecnt_o` and `cmp_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sig_i | input | 1 | Asynchronous external input |
| count_i | input | TW | Free-running timer value to capture |
| arm_set_i | input | 1 | Pulse: arm the capture process |
| arm_clr_i | input | 1 | Pulse: disarm (wins over arm_set_i) |
| oneshot_i | input | 1 | 0 free-running, 1 one-shot |
| src_sel_i | input | 1 | 0 raw input, 1 edge-counter compare output |
| edge0_i | input | 2 | Edge field of circuit 0 |
| edge1_i | input | 2 | Edge field of circuit 1 |
| flag_clr_i | input | 2 | Write-1-to-clear for flag_o |
| ecnt_en_i | input | 1 | Edge counter enable |
| ecnt_cmp_i | input | CW | Edge counter compare value |
| cap0_o | output | TW | Capture register of circuit 0 |
| cap1_o | output | TW | Capture register of circuit 1 |
| flag_o | output | 2 | Sticky capture flags |
| arm_o | output | 1 | Armed state |
| ecnt_o | output | CW | Edge counter value |
| cmp_o | output | 1 | Compare toggle output |

## Verification
The assertion on the edge counter's range assumes two things about the stimulus. First, `ecnt_cmp_i` changes only while `ecnt_en_i` is 0. Second, the compare value is nonzero whenever that assertion applies. The bench therefore drops the enable every time it loads a new compare value. The bench also switches `src_sel_i` in its directed tests only while the unit is disarmed, so that a level step on the new source cannot count as an edge. Random stimulus drives `sig_i` at clock-synchronous times only, which keeps the synchronizer latency deterministic for the reference model.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_t;

  function automatic logic edge_match(edge_sel_t sel, logic rise, logic fall);
    unique case (sel)
      EDGE_FALL: return fall;
      EDGE_RISE: return rise;
      EDGE_ANY:  return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic lvl_o,
  output logic chg_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], sig_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o = sh_q[STAGES-1];
  assign chg_o = sh_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/cap_edge_cnt.sv
module cap_edge_cnt #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          edge_i,
  input  logic [CW-1:0] cmp_i,
  output logic [CW-1:0] cnt_o,
  output logic          tog_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic          tog_q;

  assign cnt_inc = cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (edge_i) begin
      if (cnt_inc == cmp_i) begin
        cnt_q <= '0;
        tog_q <= ~tog_q;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign tog_o = tog_q;
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    sel_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          clr_i,
  input  logic [TW-1:0] count_i,
  output logic          hit_o,
  output logic [TW-1:0] cap_o,
  output logic          flag_o
);
  logic [TW-1:0] cap_q;
  logic          flag_q;

  assign hit_o = en_i & edge_match(edge_sel_t'(sel_i), rise_i, fall_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (hit_o) cap_q <= count_i;
      if (hit_o)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/cap_unit.sv
module cap_unit #(
  parameter int TW          = 16,
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sig_i,
  input  logic [TW-1:0] count_i,
  input  logic          arm_set_i,
  input  logic          arm_clr_i,
  input  logic          oneshot_i,
  input  logic          src_sel_i,
  input  logic [1:0]    edge0_i,
  input  logic [1:0]    edge1_i,
  input  logic [1:0]    flag_clr_i,
  input  logic          ecnt_en_i,
  input  logic [CW-1:0] ecnt_cmp_i,
  output logic [TW-1:0] cap0_o,
  output logic [TW-1:0] cap1_o,
  output logic [1:0]    flag_o,
  output logic          arm_o,
  output logic [CW-1:0] ecnt_o,
  output logic          cmp_o
);
  localparam int NCH = 2;

  logic           s_lvl, s_chg;
  logic           src, src_q, src_rise, src_fall;
  logic           arm_q, done0_q;
  logic [NCH-1:0] ch_en, hit;
  logic [1:0]     sel [NCH];
  logic [TW-1:0]  cap [NCH];

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sig_i),
    .lvl_o (s_lvl),
    .chg_o (s_chg)
  );

  cap_edge_cnt #(.CW(CW)) u_ecnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ecnt_en_i),
    .edge_i(s_chg),
    .cmp_i (ecnt_cmp_i),
    .cnt_o (ecnt_o),
    .tog_o (cmp_o)
  );

  assign src      = src_sel_i ? cmp_o : s_lvl;
  assign src_rise = src & ~src_q;
  assign src_fall = ~src & src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= 1'b0;
    else         src_q <= src;
  end

  // one-shot: circuit 1 waits for circuit 0
  assign ch_en[0] = arm_q & (~oneshot_i | ~done0_q);
  assign ch_en[1] = arm_q & (~oneshot_i | done0_q);
  assign sel[0]   = edge0_i;
  assign sel[1]   = edge1_i;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cap_channel #(.TW(TW)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (ch_en[i]),
      .sel_i  (sel[i]),
      .rise_i (src_rise),
      .fall_i (src_fall),
      .clr_i  (flag_clr_i[i]),
      .count_i(count_i),
      .hit_o  (hit[i]),
      .cap_o  (cap[i]),
      .flag_o (flag_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q   <= 1'b0;
      done0_q <= 1'b0;
    end else if (arm_clr_i) begin
      arm_q   <= 1'b0;
      done0_q <= 1'b0;
    end else if (arm_set_i) begin
      arm_q   <= 1'b1;
      done0_q <= 1'b0;
    end else if (oneshot_i) begin
      if (hit[1]) begin
        arm_q   <= 1'b0;
        done0_q <= 1'b0;
      end else if (hit[0]) begin
        done0_q <= 1'b1;
      end
    end
  end

  assign arm_o  = arm_q;
  assign cap0_o = cap[0];
  assign cap1_o = cap[1];
endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
  parameter int TW = 16,
  parameter int CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          arm_o,
  input logic          arm_set_i,
  input logic          oneshot_i,
  input logic [TW-1:0] cap0_o,
  input logic [TW-1:0] cap1_o,
  input logic [1:0]    flag_o,
  input logic [1:0]    flag_clr_i,
  input logic [1:0]    hit,
  input logic          ecnt_en_i,
  input logic [CW-1:0] ecnt_o,
  input logic [CW-1:0] ecnt_cmp_i,
  input logic          cmp_o
);
  p_arm_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_o |=> ($stable(cap0_o) && $stable(cap1_o)));

  p_flag0_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[0] && !flag_clr_i[0]) |=> flag_o[0]);

  p_flag1_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[1] && !flag_clr_i[1]) |=> flag_o[1]);

  p_flag_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit[0] |=> flag_o[0]);

  p_oneshot_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit[1] && oneshot_i && !arm_set_i) |=> !arm_o);

  p_ecnt_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ecnt_en_i |=> (ecnt_o == '0 && !cmp_o));

  p_ecnt_below_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecnt_en_i && ecnt_cmp_i != '0) |-> (ecnt_o < ecnt_cmp_i));
endmodule

bind cap_unit cap_unit_chk #(.TW(TW), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .arm_o     (arm_o),
  .arm_set_i (arm_set_i),
  .oneshot_i (oneshot_i),
  .cap0_o    (cap0_o),
  .cap1_o    (cap1_o),
  .flag_o    (flag_o),
  .flag_clr_i(flag_clr_i),
  .hit       (hit),
  .ecnt_en_i (ecnt_en_i),
  .ecnt_o    (ecnt_o),
  .ecnt_cmp_i(ecnt_cmp_i),
  .cmp_o     (cmp_o)
);

// File: tb/tb_cap_unit.sv
`timescale 1ns/1ps
module tb_cap_unit;
  localparam int TW = 16;
  localparam int CW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sig_i = 1'b0;
  logic [TW-1:0] count_i = '0;
  logic          arm_set_i = 1'b0, arm_clr_i = 1'b0, oneshot_i = 1'b0, src_sel_i = 1'b0;
  logic [1:0]    edge0_i = 2'b00, edge1_i = 2'b00, flag_clr_i = 2'b00;
  logic          ecnt_en_i = 1'b0;
  logic [CW-1:0] ecnt_cmp_i = 8'd4;
  logic [TW-1:0] cap0_o, cap1_o;
  logic [1:0]    flag_o;
  logic          arm_o, cmp_o;
  logic [CW-1:0] ecnt_o;

  int total = 0;
  int bad = 0;

  cap_unit #(.TW(TW), .CW(CW)) dut (.*);

  always #2.5 clk_i = ~clk_i;
  always @(negedge clk_i) count_i <= count_i + 16'd1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int unsigned m_cap0, m_cap1, m_cnt;
  bit m_flag0, m_flag1, m_arm, m_first, m_tog, m_s, m_sprev, m_srcq;
  bit sq[$];

  function automatic bit sel_hit(logic [1:0] sel, bit r, bit f);
    return (sel == 2'b01 && f) || (sel == 2'b10 && r) || (sel == 2'b11 && (r || f));
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cap0 = 0; m_cap1 = 0; m_cnt = 0;
      m_flag0 = 0; m_flag1 = 0; m_arm = 0; m_first = 0;
      m_tog = 0; m_s = 0; m_sprev = 0; m_srcq = 0;
      sq = {1'b0};
    end else begin
      bit srcv, r, f, h0, h1, e0, e1;
      int unsigned nx;
      srcv = src_sel_i ? m_tog : m_s;
      r = srcv && !m_srcq;
      f = !srcv && m_srcq;
      e0 = m_arm && (!oneshot_i || !m_first);
      e1 = m_arm && (!oneshot_i || m_first);
      h0 = e0 && sel_hit(edge0_i, r, f);
      h1 = e1 && sel_hit(edge1_i, r, f);
      if (h0) m_cap0 = count_i;
      if (h1) m_cap1 = count_i;
      if (h0) m_flag0 = 1; else if (flag_clr_i[0]) m_flag0 = 0;
      if (h1) m_flag1 = 1; else if (flag_clr_i[1]) m_flag1 = 0;
      if (arm_clr_i) begin m_arm = 0; m_first = 0; end
      else if (arm_set_i) begin m_arm = 1; m_first = 0; end
      else if (oneshot_i && h1) begin m_arm = 0; m_first = 0; end
      else if (oneshot_i && h0) m_first = 1;
      if (!ecnt_en_i) begin m_cnt = 0; m_tog = 0; end
      else if (m_s != m_sprev) begin
        nx = (m_cnt + 1) % (1 << CW);
        if (nx == ecnt_cmp_i) begin m_cnt = 0; m_tog = !m_tog; end
        else m_cnt = nx;
      end
      m_srcq = srcv;
      m_sprev = m_s;
      m_s = sq.pop_front();
      sq.push_back(sig_i);
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R1 cap0 vs model", cap0_o, m_cap0);
      chk("R2 cap1 vs model", cap1_o, m_cap1);
      chk("R6 flags vs model", flag_o, {m_flag1, m_flag0});
      chk("R5 arm vs model", arm_o, m_arm);
      chk("R8 ecnt vs model", ecnt_o, m_cnt);
      chk("R9 cmp vs model", cmp_o, m_tog);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(input logic v, output logic [TW-1:0] c);
    @(negedge clk_i);
    sig_i = v;
    #1 c = count_i;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic pulse_arm_set();
    @(negedge clk_i); arm_set_i = 1'b1;
    @(negedge clk_i); arm_set_i = 1'b0;
  endtask

  task automatic pulse_arm_clr();
    @(negedge clk_i); arm_clr_i = 1'b1;
    @(negedge clk_i); arm_clr_i = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk_i); flag_clr_i = 2'b11;
    @(negedge clk_i); flag_clr_i = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [TW-1:0] c, d, keep;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    chk("R11 cap0", cap0_o, 0);
    chk("R11 cap1", cap1_o, 0);
    chk("R11 flags", flag_o, 0);
    chk("R11 arm", arm_o, 0);
    chk("R11 ecnt", {ecnt_o, cmp_o}, 0);

    // free-running, rise on 0, fall on 1
    edge0_i = 2'b10; edge1_i = 2'b01;
    pulse_arm_set();
    chk("R4 armed", arm_o, 1);
    drive(1'b1, c);
    chk("R7 cap0 latency", cap0_o, c + 2);
    chk("R4 flag0", flag_o, 2'b01);
    keep = cap0_o;
    drive(1'b0, d);
    chk("R2 cap1 falling", cap1_o, d + 2);
    chk("R2 cap0 untouched", cap0_o, keep);
    chk("R6 both flags", flag_o, 2'b11);
    drive(1'b1, c);
    chk("R4 second capture", cap0_o, c + 2);
    clear_flags();
    chk("R6 w1c", flag_o, 2'b00);

    // any edge on 0, circuit 1 off
    edge0_i = 2'b11; edge1_i = 2'b00;
    keep = cap1_o;
    drive(1'b0, c);
    chk("R1 any edge falling", cap0_o, c + 2);
    chk("R1 off circuit flag", flag_o, 2'b01);
    chk("R1 off circuit reg", cap1_o, keep);
    drive(1'b1, c);
    chk("R1 any edge rising", cap0_o, c + 2);

    // disarmed
    pulse_arm_clr();
    chk("R3 disarm", arm_o, 0);
    keep = cap0_o;
    drive(1'b0, c);
    chk("R3 no capture", cap0_o, keep);
    chk("R3 no flag change", flag_o, 2'b01);
    clear_flags();

    // one-shot
    oneshot_i = 1'b1; edge0_i = 2'b10; edge1_i = 2'b10;
    pulse_arm_set();
    drive(1'b1, c);
    chk("R5 first cap0", cap0_o, c + 2);
    chk("R5 only flag0", flag_o, 2'b01);
    chk("R5 still armed", arm_o, 1);
    drive(1'b0, d);
    drive(1'b1, d);
    chk("R5 then cap1", cap1_o, d + 2);
    chk("R5 cap0 kept", cap0_o, c + 2);
    chk("R5 auto disarm", arm_o, 0);
    drive(1'b0, d);
    drive(1'b1, d);
    chk("R5 no recapture", cap0_o, c + 2);
    oneshot_i = 1'b0;
    clear_flags();

    // edge counter
    ecnt_cmp_i = 8'd3;
    @(negedge clk_i); ecnt_en_i = 1'b1;
    drive(1'b0, c);
    chk("R8 one edge", ecnt_o, 1);
    drive(1'b1, c);
    drive(1'b0, c);
    chk("R9 wrap count", ecnt_o, 0);
    chk("R9 toggled", cmp_o, 1);
    drive(1'b1, c);
    chk("R8 after wrap", ecnt_o, 1);
    @(negedge clk_i); ecnt_en_i = 1'b0;
    @(negedge clk_i);
    chk("R8 held count", ecnt_o, 0);
    chk("R8 held toggle", cmp_o, 0);

    // compare output as source
    ecnt_cmp_i = 8'd1; src_sel_i = 1'b1;
    edge0_i = 2'b11; edge1_i = 2'b00;
    @(negedge clk_i); ecnt_en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    pulse_arm_set();
    drive(1'b0, c);
    @(negedge clk_i);
    chk("R10 divided source", cap0_o, c + 3);
    pulse_arm_clr();
    src_sel_i = 1'b0;

    // random mix against the model
    @(negedge clk_i); ecnt_en_i = 1'b0;
    @(negedge clk_i); ecnt_cmp_i = 8'd5;
    @(negedge clk_i); ecnt_en_i = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      if ($urandom_range(3) == 0) sig_i = ~sig_i;
      arm_set_i  = ($urandom_range(40) == 0);
      arm_clr_i  = ($urandom_range(120) == 0);
      flag_clr_i = ($urandom_range(10) == 0) ? 2'($urandom) : 2'b00;
      if ($urandom_range(60) == 0) begin
        edge0_i   = 2'($urandom);
        edge1_i   = 2'($urandom);
        oneshot_i = 1'($urandom);
        src_sel_i = 1'($urandom);
      end
    end
    @(negedge clk_i);
    arm_set_i = 0; arm_clr_i = 0; flag_clr_i = 0;
    repeat (4) @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule